// File: doc/BRIEF.md
# SEU-Tolerant Serial Key Recognizer

This block watches a serial bit stream and raises a one-cycle pulse when a fixed 16-bit key has arrived. A chain of sixteen states tracks how many key bits have matched so far. A bit is taken only on a cycle where the valid strobe is high. A bit that does not match sends the machine back to the idle state. The bit that completes the key raises the pulse and also returns the machine to idle.

A parameter chooses how the sixteen states are held in the state register. The choices are a plain binary count, one-hot, binary with an even-parity bit, or a 7-bit single-error-correcting code. With the last of these, a single flipped register bit does not change the state. Two inputs corrupt state bits on purpose: a fault vector, and a select that picks where the corruption lands. It can land on the register value as it is read, or on the next-state value as it is loaded. Running the same stimulus through each encoding shows how much upset each one tolerates.

States are named `ST_IDLE` (no bits matched) and `ST_M01` to `ST_M15` (that many leading key bits matched). The transitions are:
- hold: no valid bit, so the state is kept.
- advance: a matching bit moves the machine one state on.
- restart: a mismatching bit sends the machine to `ST_IDLE`.
- finish: a matching bit in `ST_M15` sends the machine to `ST_IDLE` and pulses the output.
- abort: an illegal register value sends the machine to `ST_IDLE` whatever the input.

Top module: `seu_key_fsm`

## Requirements
- R1: While `rst_n` is low and after it rises, `key_hit` is 0 and the machine is in `ST_IDLE`. A full key sent right after reset gives a hit on its 16th bit.
- R2: Key bits are compared most significant first (`KEY[15]` first). When the 16th matching bit is accepted at a rising clock edge, `key_hit` is 1 for exactly the one cycle after that edge, and the machine returns to `ST_IDLE`.
- R3: An accepted bit that differs from the expected key bit returns the machine to `ST_IDLE`. Matched bits are not reused, and the next key must be sent in full.
- R4: When `ser_valid` is 0, `ser_bit` is ignored and the state is held, so a key may be spread over idle cycles.
- R5: `ENCODING` selects the register code for state number k:
  - 0: binary, 4 bits holding k.
  - 1: one-hot, 16 bits with only bit k set.
  - 2: parity, 5 bits with k in bits 3:0 and bit 4 = XOR of bits 3:0.
  - 3: distance-3 code, 7 bits. Bits 6:3 hold k = d3..d0, and bits 2:0 hold p2,p1,p0, where p0=d0^d1^d3, p1=d0^d2^d3 and p2=d1^d2^d3.
  - `ST_IDLE` is all zeros, except in one-hot, where it is bit 0 set.
- R6: With one-hot or parity encoding, a register value that is not a legal codeword takes the abort transition at the next edge, and `key_hit` stays 0.
- R7: With the distance-3 encoding, any value within one bit of a codeword decodes as that codeword's state. A single flipped bit therefore has no effect. Every edge writes a clean codeword unless a next-state fault is applied.
- R8: When `fault_sel` = 2'b01, the value used for that cycle's decision is the register XOR `fault_vec[W-1:0]`, where W is the register width from R5.
- R9: When `fault_sel` = 2'b10, `fault_vec[W-1:0]` is XORed into the next-state code before it is loaded.
- R10: When `fault_sel` is 2'b00 or 2'b11, `fault_vec` has no effect. Fault bits at W and above are always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Serial data bit |
| ser_valid | input | 1 | High when `ser_bit` is to be taken |
| fault_vec | input | 16 | Bits to invert in the state code |
| fault_sel | input | 2 | 00 none, 01 register read, 10 next-state load, 11 none |
| key_hit | output | 1 | One-cycle pulse after the key completes |

## Verification
A wrong internal state can be seen at the port only through `key_hit`: either a pulse that goes missing or a pulse that should not be there. The error shows at the latest when the next sixteen accepted bits would have completed a key, and a spurious pulse can appear on the very next accepted bit. For this reason the bench compares `key_hit` against a behavioural model on every cycle, for all four encodings side by side, using long streams that follow the key. The bound checker looks at the register more directly. On every cycle with no next-state fault, it checks that the register holds a clean codeword, and that an illegal value is flushed back to idle.

// File: rtl/seu_fsm_pkg.sv
package seu_fsm_pkg;

    localparam int KEY_LEN   = 16;
    localparam int IDX_W     = $clog2(KEY_LEN);
    localparam int FAULT_W   = KEY_LEN;
    localparam int HAM_PAR_W = 3;

    typedef enum logic [1:0] {
        ENC_BINARY = 2'd0,
        ENC_ONEHOT = 2'd1,
        ENC_PARITY = 2'd2,
        ENC_DIST3  = 2'd3
    } enc_e;

    localparam logic [1:0] FSEL_OFF   = 2'b00;
    localparam logic [1:0] FSEL_REG   = 2'b01;
    localparam logic [1:0] FSEL_NEXT  = 2'b10;
    localparam logic [1:0] FSEL_SPARE = 2'b11;

    typedef enum logic [IDX_W-1:0] {
        ST_IDLE, ST_M01, ST_M02, ST_M03, ST_M04, ST_M05, ST_M06, ST_M07,
        ST_M08, ST_M09, ST_M10, ST_M11, ST_M12, ST_M13, ST_M14, ST_M15
    } key_state_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_ADVANCE,
        ACT_RESTART,
        ACT_FINISH,
        ACT_ABORT
    } step_act_e;

    function automatic int state_width(enc_e e);
        case (e)
            ENC_BINARY: return IDX_W;
            ENC_ONEHOT: return KEY_LEN;
            ENC_PARITY: return IDX_W + 1;
            default:    return IDX_W + HAM_PAR_W;
        endcase
    endfunction

    // check bits of the distance-3 code: {p2, p1, p0}
    function automatic logic [HAM_PAR_W-1:0] ham_parity(logic [IDX_W-1:0] d);
        return {d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
    endfunction

endpackage

// File: rtl/seu_state_encoder.sv
module seu_state_encoder
    import seu_fsm_pkg::*;
#(
    parameter enc_e ENCODING = ENC_DIST3,
    parameter int   W        = 7
) (
    input  key_state_e     st,
    output logic [W-1:0]   code
);

    logic [IDX_W-1:0] num;
    assign num = st;

    generate
        if (ENCODING == ENC_BINARY) begin : g_bin
            assign code = W'(num);
        end else if (ENCODING == ENC_ONEHOT) begin : g_hot
            assign code = {{(W-1){1'b0}}, 1'b1} << num;
        end else if (ENCODING == ENC_PARITY) begin : g_par
            assign code = W'({^num, num});
        end else begin : g_d3
            assign code = W'({num, ham_parity(num)});
        end
    endgenerate

endmodule

// File: rtl/seu_state_decoder.sv
module seu_state_decoder
    import seu_fsm_pkg::*;
#(
    parameter enc_e ENCODING = ENC_DIST3,
    parameter int   W        = 7
) (
    input  logic [W-1:0] code,
    output key_state_e   st,
    output logic         legal
);

    generate
        if (ENCODING == ENC_BINARY) begin : g_bin
            assign st    = key_state_e'(code[IDX_W-1:0]);
            assign legal = 1'b1;
        end else if (ENCODING == ENC_ONEHOT) begin : g_hot
            logic [IDX_W-1:0] pos;
            always_comb begin
                pos = '0;
                for (int i = 0; i < W; i++) begin
                    if (code[i]) pos = IDX_W'(i);
                end
            end
            assign st    = key_state_e'(pos);
            assign legal = $onehot(code);
        end else if (ENCODING == ENC_PARITY) begin : g_par
            assign st    = key_state_e'(code[IDX_W-1:0]);
            assign legal = ~^code;
        end else begin : g_d3
            logic [HAM_PAR_W-1:0] syn;
            logic [IDX_W-1:0]     fix;
            assign syn = code[HAM_PAR_W-1:0] ^ ham_parity(code[W-1:HAM_PAR_W]);
            always_comb begin
                unique case (syn)
                    3'b011:  fix = 4'b0001;
                    3'b101:  fix = 4'b0010;
                    3'b110:  fix = 4'b0100;
                    3'b111:  fix = 4'b1000;
                    default: fix = 4'b0000;
                endcase
            end
            assign st    = key_state_e'(code[W-1:HAM_PAR_W] ^ fix);
            assign legal = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/seu_key_step.sv
module seu_key_step
    import seu_fsm_pkg::*;
#(
    parameter logic [KEY_LEN-1:0] KEY = 16'hA5C3
) (
    input  key_state_e cur,
    input  logic       legal,
    input  logic       ser_valid,
    input  logic       ser_bit,
    output key_state_e nxt,
    output logic       complete
);

    logic [IDX_W-1:0] cur_n;
    logic             want;
    step_act_e        act;

    assign cur_n = cur;
    assign want  = KEY[IDX_W'(KEY_LEN - 1) - cur_n];

    always_comb begin
        if (!legal)                 act = ACT_ABORT;
        else if (!ser_valid)        act = ACT_HOLD;
        else if (ser_bit != want)   act = ACT_RESTART;
        else if (cur == ST_M15)     act = ACT_FINISH;
        else                        act = ACT_ADVANCE;
    end

    always_comb begin
        nxt      = ST_IDLE;
        complete = 1'b0;
        unique case (act)
            ACT_HOLD:    nxt = cur;
            ACT_ADVANCE: nxt = key_state_e'(cur_n + IDX_W'(1));
            ACT_RESTART: nxt = ST_IDLE;
            ACT_FINISH: begin
                nxt      = ST_IDLE;
                complete = 1'b1;
            end
            ACT_ABORT:   nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/seu_key_fsm.sv
module seu_key_fsm
    import seu_fsm_pkg::*;
#(
    parameter enc_e               ENCODING = ENC_DIST3,
    parameter logic [KEY_LEN-1:0] KEY      = 16'hA5C3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_bit,
    input  logic               ser_valid,
    input  logic [FAULT_W-1:0] fault_vec,
    input  logic [1:0]         fault_sel,
    output logic               key_hit
);

    localparam int W = state_width(ENCODING);
    localparam logic [W-1:0] IDLE_CODE =
        (ENCODING == ENC_ONEHOT) ? {{(W-1){1'b0}}, 1'b1} : {W{1'b0}};

    logic [W-1:0] state_q;
    logic [W-1:0] fault_mask;
    logic [W-1:0] seen_code;
    logic [W-1:0] next_code;
    logic [W-1:0] load_code;
    key_state_e   cur_st;
    key_state_e   nxt_st;
    logic         cur_legal;
    logic         step_done;

    assign fault_mask = fault_vec[W-1:0];

    generate
        if (W < FAULT_W) begin : g_spare
            logic unused_fault_hi;
            assign unused_fault_hi = ^fault_vec[FAULT_W-1:W];
        end
    endgenerate

    // upset on the register as read: only this cycle's decision sees it
    assign seen_code = (fault_sel == FSEL_REG) ? (state_q ^ fault_mask) : state_q;

    seu_state_decoder #(.ENCODING(ENCODING), .W(W)) u_dec (
        .code  (seen_code),
        .st    (cur_st),
        .legal (cur_legal)
    );

    seu_key_step #(.KEY(KEY)) u_step (
        .cur       (cur_st),
        .legal     (cur_legal),
        .ser_valid (ser_valid),
        .ser_bit   (ser_bit),
        .nxt       (nxt_st),
        .complete  (step_done)
    );

    seu_state_encoder #(.ENCODING(ENCODING), .W(W)) u_enc (
        .st   (nxt_st),
        .code (next_code)
    );

    // upset on the next-state path: the corrupted code is stored
    assign load_code = (fault_sel == FSEL_NEXT) ? (next_code ^ fault_mask) : next_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE_CODE;
        else        state_q <= load_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_hit <= 1'b0;
        else        key_hit <= step_done;
    end

endmodule

// File: rtl/seu_key_fsm_chk.sv
module seu_key_fsm_chk
    import seu_fsm_pkg::*;
#(
    parameter enc_e ENCODING = ENC_DIST3,
    parameter int   W        = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ser_valid,
    input logic [1:0]   fault_sel,
    input logic         key_hit,
    input logic [W-1:0] state_q,
    input logic         cur_legal
);

    key_state_e   chk_st;
    logic         chk_legal;
    logic [W-1:0] chk_code;
    logic         chk_exact;
    logic         sel_quiet;

    seu_state_decoder #(.ENCODING(ENCODING), .W(W)) u_cdec (
        .code  (state_q),
        .st    (chk_st),
        .legal (chk_legal)
    );

    seu_state_encoder #(.ENCODING(ENCODING), .W(W)) u_cenc (
        .st   (chk_st),
        .code (chk_code)
    );

    assign chk_exact = chk_legal && (chk_code == state_q);
    assign sel_quiet = (fault_sel == FSEL_OFF) || (fault_sel == FSEL_SPARE);

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !key_hit);

    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |-> $past(ser_valid));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hit && sel_quiet && ($past(fault_sel) != FSEL_NEXT)) |=> !key_hit);

    a_r6_illegal_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_legal |=> !key_hit);

    a_r6_illegal_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_legal && (fault_sel != FSEL_NEXT)) |=> (chk_st == ST_IDLE));

    a_r7_clean_codeword: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sel != FSEL_NEXT) |=> chk_exact);

endmodule

bind seu_key_fsm seu_key_fsm_chk #(.ENCODING(ENCODING), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_valid (ser_valid),
    .fault_sel (fault_sel),
    .key_hit   (key_hit),
    .state_q   (state_q),
    .cur_legal (cur_legal)
);

// File: tb/seu_key_fsm_tb_top.sv
module seu_key_fsm_tb_top;
    import seu_fsm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TB_KEY = 16'hA5C3;

    logic        clk;
    logic        rst_n;
    logic        ser_bit;
    logic        ser_valid;
    logic [15:0] fault_vec;
    logic [1:0]  fault_sel;
    logic [3:0]  hit;

    int    checks;
    int    errors;
    int    hit_cnt [4];
    string cur_req;
    bit    running;
    bit    done;

    logic [15:0] m_reg [4];
    logic [3:0]  m_hit;

    for (genvar e = 0; e < 4; e++) begin : g_enc
        seu_key_fsm #(.ENCODING(enc_e'(e)), .KEY(TB_KEY)) dut_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ser_bit   (ser_bit),
            .ser_valid (ser_valid),
            .fault_vec (fault_vec),
            .fault_sel (fault_sel),
            .key_hit   (hit[e])
        );
    end

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int width_of(int e);
        case (e)
            0: return 4;
            1: return 16;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic logic [15:0] enc_code(int e, int k);
        logic [3:0] d;
        d = k[3:0];
        case (e)
            0: return {12'b0, d};
            1: return 16'h1 << k;
            2: return {11'b0, ^d, d};
            default: return {9'b0, d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
        endcase
    endfunction

    // -1 marks a value with no legal state
    function automatic int dec_state(int e, logic [15:0] v);
        case (e)
            0: return int'(v[3:0]);
            1: begin
                if ($countones(v) != 1) return -1;
                for (int i = 0; i < 16; i++) if (v[i]) return i;
                return -1;
            end
            2: begin
                if ($countones(v[4:0]) % 2 != 0) return -1;
                return int'(v[3:0]);
            end
            default: begin
                for (int c = 0; c < 16; c++)
                    if ($countones(enc_code(3, c) ^ v) <= 1) return c;
                return -1;
            end
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, one per encoding
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < 4; e++) begin
                m_reg[e] = enc_code(e, 0);
                m_hit[e] = 1'b0;
            end
        end else begin
            for (int e = 0; e < 4; e++) begin
                logic [15:0] mask;
                logic [15:0] seen;
                logic [15:0] nr;
                int k;
                int nk;
                bit h;
                mask = fault_vec & 16'((32'h1 << width_of(e)) - 1);
                seen = m_reg[e] ^ ((fault_sel == 2'b01) ? mask : 16'h0);
                k    = dec_state(e, seen);
                nk   = 0;
                h    = 1'b0;
                if (k >= 0) begin
                    if (!ser_valid) nk = k;
                    else if (ser_bit == TB_KEY[15-k]) begin
                        if (k == 15) h = 1'b1;
                        else nk = k + 1;
                    end
                end
                nr = enc_code(e, nk);
                if (fault_sel == 2'b10) nr = nr ^ mask;
                m_reg[e] = nr;
                m_hit[e] = h;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            for (int e = 0; e < 4; e++) begin
                check(hit[e] === m_hit[e], cur_req, $sformatf("enc%0d key_hit", e),
                      int'(hit[e]), int'(m_hit[e]));
                if (hit[e]) hit_cnt[e]++;
            end
        end
    end

    task automatic drive(logic b, logic v, logic [15:0] fv, logic [1:0] fs);
        @(negedge clk);
        #1;
        ser_bit   = b;
        ser_valid = v;
        fault_vec = fv;
        fault_sel = fs;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 16'h0, 2'b00);
    endtask

    task automatic send_key(logic [15:0] k, logic [15:0] fv, logic [1:0] fs);
        for (int i = 15; i >= 0; i--) drive(k[i], 1'b1, fv, fs);
    endtask

    task automatic send_key_rand_fault(logic [1:0] fs);
        for (int i = 15; i >= 0; i--)
            drive(TB_KEY[i], 1'b1, 16'h1 << $urandom_range(0, 6), fs);
    endtask

    task automatic clear_counts();
        for (int e = 0; e < 4; e++) hit_cnt[e] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        clear_counts();
    endtask

    task automatic expect_count(int e, int exp, string req);
        check(hit_cnt[e] == exp, req, $sformatf("enc%0d hit count", e), hit_cnt[e], exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        checks = 0;
        errors = 0;
        done = 1'b0;
        running = 1'b0;
        rst_n = 1'b0;
        ser_bit = 1'b0;
        ser_valid = 1'b0;
        fault_vec = 16'h0;
        fault_sel = 2'b00;
        cur_req = "R1";
        clear_counts();
        repeat (3) @(negedge clk);
        for (int e = 0; e < 4; e++)
            check(hit[e] === 1'b0, "R1", $sformatf("enc%0d key_hit in reset", e), int'(hit[e]), 0);
        #1;
        rst_n = 1'b1;
        running = 1'b1;

        // R1 / R2: a clean key straight after reset
        cur_req = "R2";
        send_key(TB_KEY, 16'h0, 2'b00);
        idle(2);
        for (int e = 0; e < 4; e++) expect_count(e, 1, "R1");

        // R4: bits spread over invalid cycles carrying junk data
        cur_req = "R4";
        clear_counts();
        for (int i = 15; i >= 0; i--) begin
            drive(TB_KEY[i], 1'b1, 16'h0, 2'b00);
            drive(~TB_KEY[i], 1'b0, 16'h0, 2'b00);
        end
        idle(1);
        for (int e = 0; e < 4; e++) expect_count(e, 1, "R4");
        clear_counts();
        for (int i = 15; i >= 1; i--) drive(TB_KEY[i], 1'b1, 16'h0, 2'b00);
        for (int i = 0; i < 5; i++) drive(~TB_KEY[0], 1'b0, 16'h0, 2'b00);
        for (int e = 0; e < 4; e++) expect_count(e, 0, "R4");
        drive(TB_KEY[0], 1'b1, 16'h0, 2'b00);
        idle(2);
        for (int e = 0; e < 4; e++) expect_count(e, 1, "R4");

        // R3: mismatch on last bit, then on first bit, each followed by a key
        cur_req = "R3";
        clear_counts();
        send_key(TB_KEY ^ 16'h0001, 16'h0, 2'b00);
        idle(2);
        for (int e = 0; e < 4; e++) expect_count(e, 0, "R3");
        send_key(TB_KEY, 16'h0, 2'b00);
        idle(2);
        for (int e = 0; e < 4; e++) expect_count(e, 1, "R3");
        clear_counts();
        send_key(TB_KEY ^ 16'h8000, 16'h0, 2'b00);
        send_key(TB_KEY, 16'h0, 2'b00);
        idle(2);
        for (int e = 0; e < 4; e++) expect_count(e, 1, "R3");

        // R10: fault vector with selects that apply nothing, and bits above width
        cur_req = "R10";
        do_reset();
        send_key(TB_KEY, 16'hFFFF, 2'b00);
        send_key(TB_KEY, 16'hFFFF, 2'b11);
        idle(2);
        for (int e = 0; e < 4; e++) expect_count(e, 2, "R10");
        do_reset();
        send_key(TB_KEY, 16'hFF80, 2'b01);
        send_key(TB_KEY, 16'hFF80, 2'b10);
        idle(2);
        expect_count(0, 2, "R10");
        expect_count(2, 2, "R10");
        expect_count(3, 2, "R10");

        // R7: a single upset on every cycle leaves the distance-3 machine intact
        cur_req = "R7";
        do_reset();
        repeat (4) send_key_rand_fault(2'b01);
        idle(2);
        expect_count(3, 4, "R7");
        do_reset();
        repeat (4) send_key_rand_fault(2'b10);
        idle(2);
        expect_count(3, 4, "R7");

        // R6: one upset in state 5 makes one-hot and parity abort
        cur_req = "R6";
        do_reset();
        for (int i = 15; i >= 0; i--)
            drive(TB_KEY[i], 1'b1, (i == 10) ? 16'h0001 : 16'h0, 2'b01);
        idle(2);
        expect_count(1, 0, "R6");
        expect_count(2, 0, "R6");
        expect_count(3, 1, "R7");

        // R9: next-state upset moves binary from state 8 to state 15
        cur_req = "R9";
        do_reset();
        for (int i = 15; i >= 8; i--) drive(TB_KEY[i], 1'b1, 16'h0, 2'b00);
        drive(1'b0, 1'b0, 16'h0007, 2'b10);
        drive(TB_KEY[0], 1'b1, 16'h0, 2'b00);
        idle(2);
        expect_count(0, 1, "R9");

        // R8: register-read upset lets binary state 8 act as state 15
        cur_req = "R8";
        do_reset();
        for (int i = 15; i >= 8; i--) drive(TB_KEY[i], 1'b1, 16'h0, 2'b00);
        drive(TB_KEY[0], 1'b1, 16'h0007, 2'b01);
        idle(2);
        expect_count(0, 1, "R8");

        // R5: long mixed stream with sparse faults, every encoding against the model
        cur_req = "R5";
        do_reset();
        begin
            int ptr;
            ptr = 15;
            for (int n = 0; n < 6000; n++) begin
                logic        v;
                logic        b;
                logic [15:0] fv;
                v  = ($urandom_range(0, 3) != 0);
                b  = ($urandom_range(0, 15) == 0) ? 1'($urandom_range(0, 1)) : TB_KEY[ptr];
                fv = 16'h0;
                if ($urandom_range(0, 7) == 0) fv = 16'h1 << $urandom_range(0, 15);
                if ($urandom_range(0, 31) == 0) fv = fv | (16'h1 << $urandom_range(0, 15));
                drive(b, v, fv, 2'($urandom_range(0, 3)));
                if (v) ptr = (ptr == 0) ? 15 : ptr - 1;
            end
        end
        idle(3);
        finish_run();
    end

endmodule